// File: doc/BRIEF.md
# Memory BIST Scan Test-Data Register

This block joins one memory self-test engine to a serial scan path that a test access port drives. It is two bits long. Each bit has a shift/capture flop on the scan path and an update flop behind it. The two update flops hold the engine's start and clear controls. They stay static between update operations, so the engine never sees scan data as it moves past. On a capture, the same two scan flops load the engine's completion and error flags. Those flags can then be shifted out on TDO.

Starting a test takes two steps: shift the control pattern in, then pulse update. Polling takes two steps as well: pulse capture, then shift the flags out. The register acts only while its local select is high. The scan output is retimed on the falling edge of the test clock. A TDO can therefore feed the TDI of another copy of this register, and several copies form a longer chain.

Top module: `mbist_tdr`

## Requirements
- R1: While `rst_ni` is low, `bist_invoke_o`, `bist_reset_o` and `tdo_o` are 0. This holds immediately after reset falls, without a clock edge.
- R2: Shift two bits in, first value then second, and then give one update cycle. After the update edge, `bist_invoke_o` equals the first value (bit 0) and `bist_reset_o` equals the second value (bit 1).
- R3: `bist_invoke_o` and `bist_reset_o` change only on a selected update edge. Shift and capture cycles leave them unchanged.
- R4: A selected capture loads `bist_done_i` into bit 0 and `bist_fail_i` into bit 1. On the next falling edge, `tdo_o` shows done. After one further shift, `tdo_o` shows fail.
- R5: `tdo_o` changes only on a falling edge of `tck_i`. Just after the rising edge of a shift, it still holds its previous value.
- R6: While `sel_i` is low, shift, capture and update have no effect. The outputs and both scan bits are unchanged, and `tdo_o` holds.
- R7: The scan path is exactly two bits long. A value applied on `tdi_i` at one shift edge appears on `tdo_o` after the falling edge that follows the next shift edge.
- R8: Two registers with the first one's `tdo_o` wired to the second one's `tdi_i` form a four-bit chain. After four shifts of s0..s3 and an update, the far register drives invoke=s0 and reset=s1, and the near register drives invoke=s2 and reset=s3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low test reset |
| sel_i | input | 1 | Local select for this register |
| shift_en_i | input | 1 | Shift enable |
| capture_en_i | input | 1 | Capture enable |
| update_en_i | input | 1 | Update enable |
| tdi_i | input | 1 | Serial scan input |
| tdo_o | output | 1 | Serial scan output, falling-edge retimed |
| bist_done_i | input | 1 | Engine completion flag, captured into bit 0 |
| bist_fail_i | input | 1 | Engine error flag, captured into bit 1 |
| bist_invoke_o | output | 1 | Engine start control, update stage of bit 0 |
| bist_reset_o | output | 1 | Engine clear control, update stage of bit 1 |

## Verification
The engine controls are due immediately after the rising edge of the update cycle. The scan output is due half a period later, at the falling edge that follows a shift, capture or idle selected cycle. The bench drives every cycle's enables well clear of the rising edge. It samples all outputs 6 ns after that edge, which is past the falling edge, so each check sees both registered stages settled. A second sample taken 2 ns after the rising edge confirms that `tdo_o` has not yet moved. Reset is checked 1 ns after it falls, with no clock edge in between.

// File: rtl/mbist_tdr_pkg.sv
package mbist_tdr_pkg;
  localparam int TDR_LEN    = 2;
  localparam int IDX_INVOKE = 0;  // also the done capture bit
  localparam int IDX_RESET  = 1;  // also the fail capture bit
  typedef logic [TDR_LEN-1:0] tdr_vec_t;
endpackage

// File: rtl/mbist_tdr_cell.sv
module mbist_tdr_cell (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic cap_i,
  input  logic shift_i,
  input  logic upd_i,
  input  logic cap_data_i,
  input  logic scan_in_i,
  output logic scan_q_o,
  output logic upd_q_o
);
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)       scan_q_o <= 1'b0;
    else if (cap_i)    scan_q_o <= cap_data_i;
    else if (shift_i)  scan_q_o <= scan_in_i;
  end

  // update stage samples the scan stage as it was before this edge
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)     upd_q_o <= 1'b0;
    else if (upd_i)  upd_q_o <= scan_q_o;
  end
endmodule

// File: rtl/mbist_tdr_tdo.sv
module mbist_tdr_tdo (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic bit_i,
  output logic tdo_o
);
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)     tdo_o <= 1'b0;
    else if (sel_i)  tdo_o <= bit_i;
  end
endmodule

// File: rtl/mbist_tdr.sv
module mbist_tdr
  import mbist_tdr_pkg::*;
(
  input  logic tck_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic shift_en_i,
  input  logic capture_en_i,
  input  logic update_en_i,
  input  logic tdi_i,
  output logic tdo_o,
  input  logic bist_done_i,
  input  logic bist_fail_i,
  output logic bist_invoke_o,
  output logic bist_reset_o
);
  tdr_vec_t scan_q;
  tdr_vec_t upd_q;
  tdr_vec_t scan_in;
  tdr_vec_t cap_data;

  logic cap_act, shift_act, upd_act;
  assign cap_act   = sel_i & capture_en_i;
  assign shift_act = sel_i & shift_en_i;
  assign upd_act   = sel_i & update_en_i;

  assign cap_data[IDX_INVOKE] = bist_done_i;
  assign cap_data[IDX_RESET]  = bist_fail_i;

  for (genvar i = 0; i < TDR_LEN; i++) begin : g_bit
    if (i == TDR_LEN-1) begin : g_head
      assign scan_in[i] = tdi_i;
    end else begin : g_body
      assign scan_in[i] = scan_q[i+1];
    end

    mbist_tdr_cell u_cell (
      .tck_i      (tck_i),
      .rst_ni     (rst_ni),
      .cap_i      (cap_act),
      .shift_i    (shift_act),
      .upd_i      (upd_act),
      .cap_data_i (cap_data[i]),
      .scan_in_i  (scan_in[i]),
      .scan_q_o   (scan_q[i]),
      .upd_q_o    (upd_q[i])
    );
  end

  mbist_tdr_tdo u_tdo (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .sel_i  (sel_i),
    .bit_i  (scan_q[0]),
    .tdo_o  (tdo_o)
  );

  assign bist_invoke_o = upd_q[IDX_INVOKE];
  assign bist_reset_o  = upd_q[IDX_RESET];
endmodule

// File: rtl/mbist_tdr_chk.sv
module mbist_tdr_chk
  import mbist_tdr_pkg::*;
(
  input logic     tck_i,
  input logic     rst_ni,
  input logic     sel_i,
  input logic     shift_en_i,
  input logic     capture_en_i,
  input logic     update_en_i,
  input logic     tdi_i,
  input logic     tdo_o,
  input logic     bist_done_i,
  input logic     bist_fail_i,
  input logic     bist_invoke_o,
  input logic     bist_reset_o,
  input tdr_vec_t scan_q,
  input tdr_vec_t upd_q
);
  AST_CTRL_STATIC: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !(sel_i && update_en_i) |=> $stable({bist_reset_o, bist_invoke_o})); // R3

  AST_UPDATE_LOAD: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (sel_i && update_en_i) |=> (bist_invoke_o == $past(scan_q[IDX_INVOKE]))
                             && (bist_reset_o == $past(scan_q[IDX_RESET]))); // R2

  AST_CAPTURE_LOAD: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (sel_i && capture_en_i) |=> (scan_q[IDX_INVOKE] == $past(bist_done_i))
                              && (scan_q[IDX_RESET] == $past(bist_fail_i))); // R4

  AST_SHIFT_MOVE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (sel_i && shift_en_i && !capture_en_i) |=>
      (scan_q[1] == $past(tdi_i)) && (scan_q[0] == $past(scan_q[1]))); // R7

  AST_DESEL_HOLD: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !sel_i |=> $stable(scan_q) && $stable(upd_q)); // R6

  AST_TDO_FALL: assert property (@(negedge tck_i) disable iff (!rst_ni)
    sel_i |=> (tdo_o == $past(scan_q[0]))); // R5

  AST_TDO_HOLD: assert property (@(negedge tck_i) disable iff (!rst_ni)
    !sel_i |=> $stable(tdo_o)); // R6
endmodule

bind mbist_tdr mbist_tdr_chk u_chk (
  .tck_i         (tck_i),
  .rst_ni        (rst_ni),
  .sel_i         (sel_i),
  .shift_en_i    (shift_en_i),
  .capture_en_i  (capture_en_i),
  .update_en_i   (update_en_i),
  .tdi_i         (tdi_i),
  .tdo_o         (tdo_o),
  .bist_done_i   (bist_done_i),
  .bist_fail_i   (bist_fail_i),
  .bist_invoke_o (bist_invoke_o),
  .bist_reset_o  (bist_reset_o),
  .scan_q        (scan_q),
  .upd_q         (upd_q)
);

// File: tb/mbist_tdr_bench.sv
module mbist_tdr_bench;
  logic tck = 1'b0;
  always #5 tck = ~tck;

  logic rst_n, sel, sh, cap, upd, tdi, done_a, fail_a;
  logic tdo_a, inv_a, clr_a, tdo_b, inv_b, clr_b;
  logic tdo_early;
  int checks = 0;
  int errors = 0;

  mbist_tdr u_mbist_tdr (
    .tck_i(tck), .rst_ni(rst_n), .sel_i(sel), .shift_en_i(sh),
    .capture_en_i(cap), .update_en_i(upd), .tdi_i(tdi), .tdo_o(tdo_a),
    .bist_done_i(done_a), .bist_fail_i(fail_a),
    .bist_invoke_o(inv_a), .bist_reset_o(clr_a)
  );

  // far register of a two-deep chain (R8)
  mbist_tdr u_mbist_tdr_far (
    .tck_i(tck), .rst_ni(rst_n), .sel_i(sel), .shift_en_i(sh),
    .capture_en_i(cap), .update_en_i(upd), .tdi_i(tdo_a), .tdo_o(tdo_b),
    .bist_done_i(1'b0), .bist_fail_i(1'b0),
    .bist_invoke_o(inv_b), .bist_reset_o(clr_b)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one cycle; returns 6 ns after the rising edge (past the falling edge)
  task automatic cyc(input logic s, input logic sh_v, input logic cap_v,
                     input logic upd_v, input logic tdi_v);
    sel = s; sh = sh_v; cap = cap_v; upd = upd_v; tdi = tdi_v;
    @(posedge tck);
    #2 tdo_early = tdo_a;
    #4;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] prev;
    logic [4:0] seq;
    logic [3:0] pat;
    rst_n = 1'b0;
    sel = 0; sh = 0; cap = 0; upd = 0; tdi = 0; done_a = 0; fail_a = 0;
    #3;
    chk("R1 invoke in reset", inv_a, 0);
    chk("R1 reset in reset", clr_a, 0);
    chk("R1 tdo in reset", tdo_a, 0);
    @(posedge tck); #6;
    rst_n = 1'b1;

    // R2/R3: every control pattern
    prev = 2'b00;
    for (int v = 0; v < 4; v++) begin
      logic [1:0] vv;
      vv = v[1:0];
      cyc(1, 1, 0, 0, vv[0]);
      chk("R3 ctrl static during shift", {clr_a, inv_a}, prev);
      cyc(1, 1, 0, 0, vv[1]);
      chk("R3 ctrl static during shift", {clr_a, inv_a}, prev);
      cyc(1, 0, 0, 1, 0);
      chk("R2 invoke after update", inv_a, vv[0]);
      chk("R2 reset after update", clr_a, vv[1]);
      prev = vv;
    end

    // R4/R5: every status pattern
    for (int d = 0; d < 4; d++) begin
      logic [1:0] dd;
      dd = d[1:0];
      done_a = dd[0]; fail_a = dd[1];
      cyc(1, 0, 1, 0, 0);
      chk("R3 ctrl static during capture", {clr_a, inv_a}, prev);
      chk("R4 tdo shows done", tdo_a, dd[0]);
      cyc(1, 1, 0, 0, 0);
      chk("R5 tdo held after rising edge", tdo_early, dd[0]);
      chk("R4 tdo shows fail", tdo_a, dd[1]);
    end

    // R7: length two
    seq = 5'b01101;
    for (int k = 0; k < 5; k++) begin
      cyc(1, 1, 0, 0, seq[k]);
      if (k >= 1) chk("R7 two-bit delay", tdo_a, seq[k-1]);
      if (k >= 2) chk("R5 tdo held after rising edge", tdo_early, seq[k-2]);
    end

    // R6: deselected operations
    cyc(1, 1, 0, 0, 1);
    cyc(1, 1, 0, 0, 0);
    cyc(1, 0, 0, 1, 0);
    chk("R2 invoke after update", inv_a, 1);
    chk("R2 reset after update", clr_a, 0);
    done_a = 0; fail_a = 1;
    cyc(0, 1, 0, 0, 0);
    chk("R6 tdo hold", tdo_a, 1);
    cyc(0, 0, 1, 0, 0);
    chk("R6 tdo hold", tdo_a, 1);
    cyc(0, 0, 0, 1, 0);
    chk("R6 ctrl unchanged", {clr_a, inv_a}, 2'b01);
    cyc(0, 1, 0, 1, 1);
    chk("R6 ctrl unchanged", {clr_a, inv_a}, 2'b01);
    chk("R6 tdo hold", tdo_a, 1);
    cyc(1, 0, 0, 0, 0);
    chk("R6 bit0 kept", tdo_a, 1);
    cyc(1, 1, 0, 0, 0);
    chk("R6 bit1 kept", tdo_a, 0);

    // R1: asynchronous reset mid-run
    cyc(1, 1, 0, 0, 1);
    cyc(1, 1, 0, 0, 1);
    cyc(1, 0, 0, 1, 0);
    chk("R2 both set", {clr_a, inv_a}, 2'b11);
    #1 rst_n = 1'b0;
    #1;
    chk("R1 async clear ctrl", {clr_a, inv_a}, 2'b00);
    chk("R1 async clear tdo", tdo_a, 0);
    @(posedge tck); #6;
    rst_n = 1'b1;

    // R8: chained pair
    for (int p = 0; p < 2; p++) begin
      pat = (p == 0) ? 4'b0110 : 4'b1011;
      for (int k = 0; k < 4; k++) cyc(1, 1, 0, 0, pat[k]);
      cyc(1, 0, 0, 1, 0);
      chk("R8 far invoke", inv_b, pat[0]);
      chk("R8 far reset", clr_b, pat[1]);
      chk("R8 near invoke", inv_a, pat[2]);
      chk("R8 near reset", clr_a, pat[3]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule